// File: doc/BRIEF.md
# Four-Digit Decimal Up/Down Counter with Selectable Rate

This block keeps a four-digit decimal count, one BCD nibble per digit, and advances it by one at a rate chosen by a speed level. A prescaler divides the system clock into a one-cycle step pulse. Level 0 stops the count. Levels 1 to 5 halve the step period at each level, so level 5 is the fastest. A direction switch picks counting up or down. The count wraps at both ends of the 0000 to 9999 range.

A pause input holds the count and the prescaler. A synchronous active-low reset clears everything. A lap switch freezes only the displayed copy of the count; the live count keeps running underneath. Releasing the lap switch makes the display show the live count again at once. Each displayed digit is also decoded into seven segment lines. Scanning or multiplexing of physical displays is left to the surrounding logic.

Top module: `bcd_speed_counter`

## Requirements
- R1: `live_bcd` holds four BCD digits. Bits [3:0] are the units, then tens, hundreds and thousands. No digit ever holds a value above 9.
- R2: At a speed level L from 1 to MAX_LEVEL, the step period is P = max(1, BASE_DIV >> (L-1)) clock cycles. The first step lands P+1 cycles after the first rising edge that sees the new level, and each later step follows P cycles after the one before.
- R3: A speed level of 0, or any level above MAX_LEVEL, never advances the count.
- R4: Counting up, a digit carries into the next digit only when it wraps from 9 to 0, and 9999 rolls over to 0000.
- R5: Counting down, a digit borrows from the next digit only when it wraps from 0 to 9, and 0000 rolls under to 9999.
- R6: A change of `count_down` takes effect on the next step and does not restart the prescaler.
- R7: A change of speed level restarts the prescaler from zero, so the next step follows the R2 timing measured from that change.
- R8: While `hold` is high, neither the count nor the prescaler advances. At level 5 with BASE_DIV of 16, the first step after release lands on the second rising edge.
- R9: `rst_n` low at a rising edge clears the live count, the displayed count and the prescaler. It takes priority over `hold` and over counting.
- R10: While `lap_freeze` is high, `shown_bcd` keeps the value the live count had when the switch rose, and `live_bcd` keeps advancing.
- R11: While `lap_freeze` is low, `shown_bcd` equals `live_bcd`, including in the same cycle the switch is released.
- R12: `shown_seg` gives seven active-high lines per displayed digit. Bits [6:0] belong to the units digit, and within a digit bit 0 is segment a through bit 6 segment g. The codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_lvl | input | LVL_W (3) | Speed level, 0 = stopped |
| count_down | input | 1 | 1 = count down, 0 = count up |
| hold | input | 1 | Pause counting and the prescaler |
| lap_freeze | input | 1 | Freeze the displayed value |
| live_bcd | output | 4*DIGITS (16) | Live count, BCD, units in the low nibble |
| shown_bcd | output | 4*DIGITS (16) | Displayed count, BCD |
| shown_seg | output | 7*DIGITS (28) | Segment lines of the displayed digits |

## Verification
The bench builds the block with BASE_DIV of 16 and the default MAX_LEVEL of 5. This gives step periods of 16, 8, 4, 2 and 1 cycles, so every level's exact step cycle can be checked in a few dozen clocks. Level 5 steps on every cycle, which brings both wrap points, the carry across several digits and the lap freeze into short runs. A 3-bit level port also lets the bench drive the out-of-range levels 6 and 7.

// File: rtl/bcd_ctr_pkg.sv
// Package: shared types and the period rule for the rate prescaler.
// Assumes levels count from 1; level 0 is handled by the caller.
package bcd_ctr_pkg;

    typedef logic [3:0] bcd_t;

    // Step period in clock cycles for a level of 1 or more (never below 1).
    function automatic int unsigned step_period(input int unsigned base,
                                                input int unsigned lvl);
        int unsigned p;
        p = (lvl == 0) ? base : (base >> (lvl - 1));
        if (p == 0) p = 1;
        return p;
    endfunction

endpackage

// File: rtl/rate_tick_gen.sv
// Module: rate_tick_gen
// Divides the clock into a one-cycle step pulse whose period depends on
// the speed level. Restarts from zero whenever the level changes, holds
// while paused, and stays idle for level 0 or levels above MAX_LEVEL.
// Assumes a synchronous active-low reset.
module rate_tick_gen
    import bcd_ctr_pkg::*;
#(
    parameter int unsigned BASE_DIV  = 50_000_000,
    parameter int unsigned MAX_LEVEL = 5,
    parameter int unsigned LVL_W     = 3,
    localparam int unsigned CNT_W    = $clog2(BASE_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] speed_lvl,
    input  logic             hold,
    output logic             step_tick
);

    logic [LVL_W-1:0] lvl_q;
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] last_val;
    logic             lvl_active;
    logic             tick_q;

    // Decode the stored level into the last count value of a period.
    always_comb begin
        int unsigned per;
        per        = step_period(BASE_DIV, int'(lvl_q));
        last_val   = CNT_W'(per - 1);
        lvl_active = (lvl_q != '0) && (int'(lvl_q) <= int'(MAX_LEVEL));
    end

    // Advance the divider, restart it on a level change, emit the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (speed_lvl != lvl_q) begin
            lvl_q  <= speed_lvl;
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (hold || !lvl_active) begin
            tick_q <= 1'b0;
        end else if (div_q == last_val) begin
            div_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign step_tick = tick_q;

endmodule

// File: rtl/bcd_digit_cell.sv
// Module: bcd_digit_cell
// One decimal digit of the counter. Steps up or down when told to,
// wraps 9->0 or 0->9, and flags the wrap so the next digit can step.
// Also exposes its next value so a neighbour can capture it.
module bcd_digit_cell
    import bcd_ctr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic down,
    output bcd_t digit_q,
    output bcd_t digit_nxt,
    output logic wrap_out
);

    logic at_edge;

    // Work out the next digit value and whether this step wraps.
    always_comb begin
        at_edge  = down ? (digit_q == 4'd0) : (digit_q == 4'd9);
        wrap_out = step_in && at_edge;
        if (!step_in)
            digit_nxt = digit_q;
        else if (down)
            digit_nxt = at_edge ? 4'd9 : digit_q - 4'd1;
        else
            digit_nxt = at_edge ? 4'd0 : digit_q + 4'd1;
    end

    // Hold the digit.
    always_ff @(posedge clk) begin
        if (!rst_n) digit_q <= 4'd0;
        else        digit_q <= digit_nxt;
    end

endmodule

// File: rtl/seg7_decode.sv
// Module: seg7_decode
// Maps one BCD digit to seven active-high segment lines, bit 0 = a
// through bit 6 = g. Values above 9 blank the digit.
module seg7_decode
    import bcd_ctr_pkg::*;
(
    input  bcd_t       digit,
    output logic [6:0] seg
);

    // Segment lookup.
    always_comb begin
        unique case (digit)
            4'd0:    seg = 7'h3F;
            4'd1:    seg = 7'h06;
            4'd2:    seg = 7'h5B;
            4'd3:    seg = 7'h4F;
            4'd4:    seg = 7'h66;
            4'd5:    seg = 7'h6D;
            4'd6:    seg = 7'h7D;
            4'd7:    seg = 7'h07;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h6F;
            default: seg = 7'h00;
        endcase
    end

endmodule

// File: rtl/bcd_speed_counter.sv
// Module: bcd_speed_counter
// Multi-digit BCD up/down counter stepped by a level-selected prescaler.
// It has pause, synchronous active-low reset (priority: reset > pause >
// count) and a lap freeze that holds only the displayed copy.
// Assumes the inputs are synchronous to clk and already debounced.
module bcd_speed_counter
    import bcd_ctr_pkg::*;
#(
    parameter int unsigned DIGITS    = 4,
    parameter int unsigned BASE_DIV  = 50_000_000,
    parameter int unsigned MAX_LEVEL = 5,
    localparam int unsigned LVL_W    = $clog2(MAX_LEVEL + 1),
    localparam int unsigned BCD_W    = 4 * DIGITS,
    localparam int unsigned SEG_W    = 7 * DIGITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] speed_lvl,
    input  logic             count_down,
    input  logic             hold,
    input  logic             lap_freeze,
    output logic [BCD_W-1:0] live_bcd,
    output logic [BCD_W-1:0] shown_bcd,
    output logic [SEG_W-1:0] shown_seg
);

    logic             step_tick;
    logic [DIGITS:0]  step_chain;
    logic [BCD_W-1:0] live_nxt;
    logic [BCD_W-1:0] lap_q;

    rate_tick_gen #(
        .BASE_DIV  (BASE_DIV),
        .MAX_LEVEL (MAX_LEVEL),
        .LVL_W     (LVL_W)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_lvl (speed_lvl),
        .hold      (hold),
        .step_tick (step_tick)
    );

    // The lowest digit steps on a tick unless paused.
    assign step_chain[0] = step_tick && !hold;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        bcd_digit_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_in   (step_chain[gi]),
            .down      (count_down),
            .digit_q   (live_bcd[4*gi +: 4]),
            .digit_nxt (live_nxt[4*gi +: 4]),
            .wrap_out  (step_chain[gi+1])
        );
    end

    // Track the live count while the lap switch is off; hold it while on.
    always_ff @(posedge clk) begin
        if (!rst_n)          lap_q <= '0;
        else if (!lap_freeze) lap_q <= live_nxt;
    end

    assign shown_bcd = lap_freeze ? lap_q : live_bcd;

    for (genvar gs = 0; gs < DIGITS; gs++) begin : g_seg
        seg7_decode u_seg (
            .digit (shown_bcd[4*gs +: 4]),
            .seg   (shown_seg[7*gs +: 7])
        );
    end

endmodule

// File: rtl/bcd_speed_counter_chk.sv
// Module: bcd_speed_counter_chk
// Property checker bound to bcd_speed_counter. Watches only its ports.
module bcd_speed_counter_chk #(
    parameter int unsigned DIGITS    = 4,
    parameter int unsigned MAX_LEVEL = 5,
    parameter int unsigned LVL_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  speed_lvl,
    input logic              hold,
    input logic              lap_freeze,
    input logic [4*DIGITS-1:0] live_bcd,
    input logic [4*DIGITS-1:0] shown_bcd
);

    for (genvar gd = 0; gd < DIGITS; gd++) begin : g_bcd
        AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (!rst_n)
            live_bcd[4*gd +: 4] <= 4'd9); // R1
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_lvl == '0 || int'(speed_lvl) > int'(MAX_LEVEL)) |=> $stable(live_bcd)); // R3

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(live_bcd)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (live_bcd == '0 && shown_bcd == '0)); // R9

    AST_LAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        lap_freeze |=> (!lap_freeze || $stable(shown_bcd))); // R10

endmodule

bind bcd_speed_counter bcd_speed_counter_chk #(
    .DIGITS    (DIGITS),
    .MAX_LEVEL (MAX_LEVEL),
    .LVL_W     (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .speed_lvl  (speed_lvl),
    .hold       (hold),
    .lap_freeze (lap_freeze),
    .live_bcd   (live_bcd),
    .shown_bcd  (shown_bcd)
);

// File: tb/bcd_speed_counter_test.sv
// Directed bench for bcd_speed_counter, built with BASE_DIV = 16.
module bcd_speed_counter_test;

    localparam int unsigned DIGITS = 4;
    localparam int unsigned BDIV   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  speed_lvl = 3'd0;
    logic        count_down = 1'b0;
    logic        hold = 1'b0;
    logic        lap_freeze = 1'b0;
    logic [15:0] live_bcd;
    logic [15:0] shown_bcd;
    logic [27:0] shown_seg;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    bcd_speed_counter #(.DIGITS(DIGITS), .BASE_DIV(BDIV), .MAX_LEVEL(5)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .speed_lvl  (speed_lvl),
        .count_down (count_down),
        .hold       (hold),
        .lap_freeze (lap_freeze),
        .live_bcd   (live_bcd),
        .shown_bcd  (shown_bcd),
        .shown_seg  (shown_seg)
    );

    always #4 clk = ~clk;

    function automatic int from_bcd(input logic [15:0] v);
        return int'(v[3:0]) + 10*int'(v[7:4]) + 100*int'(v[11:8]) + 1000*int'(v[15:12]);
    endfunction

    function automatic logic [6:0] seg_of(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; speed_lvl = 3'd0; hold = 1'b0; lap_freeze = 1'b0; count_down = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(1);
    endtask

    task automatic chk_seg(input string req, input int val);
        int v = val;
        for (int i = 0; i < 4; i++) begin
            chk(req, int'(shown_seg[7*i +: 7]), int'(seg_of(v % 10)));
            v = v / 10;
        end
    endtask

    // R9 R12: state after reset.
    task automatic t_reset();
        do_reset();
        chk("R9 live", from_bcd(live_bcd), 0);
        chk("R9 shown", from_bcd(shown_bcd), 0);
        chk_seg("R12 zeros", 0);
    endtask

    // R2: exact step cycle at each level.
    task automatic t_rates();
        for (int lv = 1; lv <= 5; lv++) begin
            int per = (BDIV >> (lv - 1));
            do_reset();
            speed_lvl = 3'(lv);
            edges(3*per + 1);
            chk($sformatf("R2 lvl%0d before", lv), from_bcd(live_bcd), 2);
            edges(1);
            chk($sformatf("R2 lvl%0d at", lv), from_bcd(live_bcd), 3);
        end
    endtask

    // R3: idle and out-of-range levels.
    task automatic t_idle();
        do_reset();
        edges(40);
        chk("R3 level0", from_bcd(live_bcd), 0);
        speed_lvl = 3'd6; edges(40);
        chk("R3 level6", from_bcd(live_bcd), 0);
        speed_lvl = 3'd7; edges(40);
        chk("R3 level7", from_bcd(live_bcd), 0);
    endtask

    // R5 R6 R4 R12: roll under, reverse, roll over.
    task automatic t_wrap();
        do_reset();
        count_down = 1'b1; speed_lvl = 3'd5;
        edges(3);
        chk("R5 rollunder", from_bcd(live_bcd), 9999);
        chk_seg("R12 nines", 9999);
        edges(1);
        chk("R5 down", from_bcd(live_bcd), 9998);
        count_down = 1'b0;
        edges(1);
        chk("R6 reverse", from_bcd(live_bcd), 9999);
        edges(1);
        chk("R4 rollover", from_bcd(live_bcd), 0);
    endtask

    // R4 R1: carries only on digit wrap.
    task automatic t_carry();
        do_reset();
        speed_lvl = 3'd5;
        edges(11);
        chk("R4 units", from_bcd(live_bcd), 9);
        edges(1);
        chk("R4 carry tens", int'(live_bcd), 16'h0010);
        edges(90);
        chk("R4 carry hundreds", int'(live_bcd), 16'h0100);
        chk_seg("R12 hundred", 100);
    endtask

    // R7: level change restarts the prescaler.
    task automatic t_relevel();
        do_reset();
        speed_lvl = 3'd1;
        edges(10);
        speed_lvl = 3'd2;
        edges(9);
        chk("R7 not yet", from_bcd(live_bcd), 0);
        edges(1);
        chk("R7 first step", from_bcd(live_bcd), 1);
    endtask

    // R8 R9: pause, resume, reset over pause.
    task automatic t_pause();
        do_reset();
        speed_lvl = 3'd5;
        edges(5);
        chk("R8 pre", from_bcd(live_bcd), 3);
        hold = 1'b1;
        edges(20);
        chk("R8 held", from_bcd(live_bcd), 3);
        hold = 1'b0;
        edges(1);
        chk("R8 resume gap", from_bcd(live_bcd), 3);
        edges(1);
        chk("R8 resumed", from_bcd(live_bcd), 4);
        hold = 1'b1; rst_n = 1'b0;
        edges(1);
        chk("R9 priority", from_bcd(live_bcd), 0);
        rst_n = 1'b1; hold = 1'b0;
    endtask

    // R10 R11: lap freeze and release.
    task automatic t_lap();
        do_reset();
        speed_lvl = 3'd5;
        edges(5);
        lap_freeze = 1'b1;
        #1;
        chk("R10 capture", from_bcd(shown_bcd), 3);
        @(negedge clk);
        edges(9);
        chk("R10 frozen", from_bcd(shown_bcd), 3);
        chk("R10 live runs", from_bcd(live_bcd), 13);
        chk_seg("R12 frozen seg", 3);
        lap_freeze = 1'b0;
        #1;
        chk("R11 release", from_bcd(shown_bcd), 13);
        @(negedge clk);
        edges(1);
        chk("R11 tracking", from_bcd(shown_bcd), from_bcd(live_bcd));
        chk("R11 value", from_bcd(shown_bcd), 15);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rates();
        t_idle();
        t_wrap();
        t_carry();
        t_relevel();
        t_pause();
        t_lap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule